// File: doc/BRIEF.md
# Quadrature Numerically Controlled Oscillator with Bounded Tuning

This block is the local oscillator of a carrier-recovery loop. Each time a sample strobe arrives, it takes one signed control word from the loop filter. The word is saturated to a symmetric window of ±2000 units and turned into a phase increment around a fixed centre of one quarter of the sample rate. The oscillator gain is 0.5 Hz per unit. With a 106666.66 Hz sample rate, the output frequency therefore stays between 25666.66 Hz and 27666.66 Hz. A positive control word raises the frequency and a negative one lowers it.

A 32-bit phase register advances by the increment on every strobe. Its top eight bits address a sine table that stores one quarter of a wave and rebuilds the other three quarters by symmetry. The block produces two outputs from the same phase:
- an in-phase reference (cosine);
- a quadrature reference (sine), which runs 90 degrees behind the in-phase output.

The increment currently in use is also brought out, so the loop's frequency estimate can be watched.

The table lookup decodes the phase quadrant as an enumerated state: rising-positive, falling-positive, falling-negative and rising-negative. The clamp decodes a tuning mode in the same way: low-saturated, pass-through or high-saturated. A mode is chosen afresh for each control word, with no memory between words.

Top module: `quad_nco`

## Requirements
- R1: A synchronous active-high reset sets the phase to zero and the reported increment to the centre value 2^30. While the phase is zero, the sine output is the first table point (≈ +402) and the cosine output is ≈ +32765.
- R2: A control word above +2000 acts as +2000, and a word below -2000 acts as -2000. The reported increment never leaves the range 2^30 ± 2000·20133.
- R3: The increment is 2^30 + c·20133, where c is the clamped control word and 20133 is round(0.5·2^32/106666.66). So c > 0 gives an increment above 2^30 and c < 0 gives one below it.
- R4: Each strobe adds the newly computed increment to the 32-bit phase, modulo 2^32. The new increment is reported from the same clock edge.
- R5: A cycle without a strobe leaves the phase, both outputs and the reported increment unchanged, whatever the control word is.
- R6: With p equal to phase bits [31:24], the sine output is round(32767·sin(2π(p+0.5)/256)), within ±2 LSB.
- R7: The cosine output is the same table read at p+64, which is round(32767·cos(2π(p+0.5)/256)) within ±2 LSB. In the first quadrant both outputs are positive; in the second, the sine is positive and the cosine negative.
- R8: The outputs and the reported increment follow the phase register directly. After a strobe at one clock edge, they show the new phase and increment before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Advance strobe, one step per high cycle |
| loop_ctrl | input | 16 | Signed frequency control word from the loop filter |
| ref_cos | output | 16 | Signed in-phase reference sample |
| ref_sin | output | 16 | Signed quadrature reference sample |
| freq_word | output | 32 | Phase increment applied at the last strobe |

## Verification
A wrong phase value appears on the reference outputs and persists. Because the phase is a running sum, one bad step shifts every later sample, so the scoreboard sees a mismatch on the first strobe that moves the phase into a different table bin. A wrong clamp or gain shows up exactly on `freq_word` in the same cycle as the strobe that caused it. A quadrant decode error makes the sign or mirror of the samples wrong as soon as the phase enters the affected quarter; a run of a few hundred steps at each tuning setting sweeps all four quarters.

// File: rtl/nco_pkg.sv
package nco_pkg;

    // Quadrant of the phase as seen by the sine table
    typedef enum logic [1:0] {
        QD_RISE_POS = 2'd0,
        QD_FALL_POS = 2'd1,
        QD_FALL_NEG = 2'd2,
        QD_RISE_NEG = 2'd3
    } quad_e;

    // Tuning mode chosen by the clamp
    typedef enum logic [1:0] {
        TUNE_LOW  = 2'd0,
        TUNE_PASS = 2'd1,
        TUNE_HIGH = 2'd2
    } tune_e;

    // The table addresses 256 points per turn; the recurrence constants below
    // are fixed to that resolution.
    localparam int TABLE_AW = 8;

    // Quarter-wave point idx: amp * sin(pi*(idx+0.5)/128), computed with a
    // second-order recurrence in 2^30 fixed point at elaboration.
    function automatic logic [15:0] quarter_point(input int idx, input int amp);
        longint two_cos;
        longint s_a;
        longint s_b;
        longint s_n;
        longint prod;
        two_cos = 64'sd2146836866;
        s_a     = 64'sd13176464;
        s_b     = 64'sd39521455;
        for (int k = 0; k < idx; k++) begin
            s_n = ((two_cos * s_b + 64'sd536870912) >>> 30) - s_a;
            s_a = s_b;
            s_b = s_n;
        end
        prod = (s_a * longint'(amp) + 64'sd536870912) >>> 30;
        return prod[15:0];
    endfunction

endpackage

// File: rtl/nco_tune.sv
module nco_tune
    import nco_pkg::*;
#(
    parameter int CTRL_W = 16,
    parameter int ACC_W  = 32,
    parameter int LIMIT  = 2000,
    parameter int STEP   = 20133
) (
    input  logic signed [CTRL_W-1:0] ctrl_in,
    output logic        [ACC_W-1:0]  inc_out
);
    localparam logic signed [CTRL_W-1:0] LIM_HI = CTRL_W'(LIMIT);
    localparam logic signed [CTRL_W-1:0] LIM_LO = -CTRL_W'(LIMIT);
    localparam logic signed [ACC_W-1:0]  STEP_S = ACC_W'(STEP);
    localparam logic        [ACC_W-1:0]  CENTER = ACC_W'(1) << (ACC_W - 2);

    tune_e                     mode;
    logic signed [CTRL_W-1:0]  clamped;
    logic signed [ACC_W-1:0]   delta;

    always_comb begin
        if (ctrl_in > LIM_HI) begin
            mode = TUNE_HIGH;
        end else if (ctrl_in < LIM_LO) begin
            mode = TUNE_LOW;
        end else begin
            mode = TUNE_PASS;
        end
    end

    always_comb begin
        unique case (mode)
            TUNE_HIGH: clamped = LIM_HI;
            TUNE_LOW:  clamped = LIM_LO;
            TUNE_PASS: clamped = ctrl_in;
            default:   clamped = '0;
        endcase
        delta   = ACC_W'(clamped) * STEP_S;
        inc_out = CENTER + delta;
    end

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  logic [ACC_W-1:0] inc_in,
    output logic [ACC_W-1:0] phase_o,
    output logic [ACC_W-1:0] inc_o
);
    localparam logic [ACC_W-1:0] CENTER = ACC_W'(1) << (ACC_W - 2);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_o <= '0;
            inc_o   <= CENTER;
        end else if (step_en) begin
            phase_o <= phase_o + inc_in;
            inc_o   <= inc_in;
        end
    end

    // R1: reset lands on zero phase and the centre increment
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (phase_o == '0 && inc_o == CENTER));

    // R4: a strobe adds the increment presented at that edge
    p_advance_r4: assert property (@(posedge clk) disable iff (rst)
        (step_en && !$past(rst)) |=> (phase_o == $past(phase_o) + $past(inc_in)));

    // R5: no strobe, no movement
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> ($stable(phase_o) && $stable(inc_o)));

endmodule

// File: rtl/nco_quarter_lut.sv
module nco_quarter_lut
    import nco_pkg::*;
#(
    parameter int OUT_W = 16,
    parameter int AMP   = 32767
) (
    input  logic [TABLE_AW-1:0]     addr,
    output logic signed [OUT_W-1:0] sample
);
    localparam int QAW = TABLE_AW - 2;
    localparam int QN  = 1 << QAW;

    logic [OUT_W-1:0] rom [QN];

    for (genvar g = 0; g < QN; g++) begin : g_rom
        localparam logic [15:0] PT = quarter_point(g, AMP);
        assign rom[g] = OUT_W'(PT);
    end

    quad_e              quad;
    logic [QAW-1:0]     idx;
    logic [QAW-1:0]     idx_mir;
    logic signed [OUT_W-1:0] mag;

    always_comb begin
        quad    = quad_e'(addr[TABLE_AW-1 -: 2]);
        idx     = addr[QAW-1:0];
        idx_mir = ~idx;
        unique case (quad)
            QD_RISE_POS: begin mag = $signed(rom[idx]);     sample =  mag; end
            QD_FALL_POS: begin mag = $signed(rom[idx_mir]); sample =  mag; end
            QD_FALL_NEG: begin mag = $signed(rom[idx]);     sample = -mag; end
            QD_RISE_NEG: begin mag = $signed(rom[idx_mir]); sample = -mag; end
            default:     begin mag = '0;                    sample = '0;   end
        endcase
    end

endmodule

// File: rtl/quad_nco.sv
module quad_nco
    import nco_pkg::*;
#(
    parameter int CTRL_W = 16,
    parameter int ACC_W  = 32,
    parameter int OUT_W  = 16,
    parameter int LIMIT  = 2000,
    parameter int STEP   = 20133,
    parameter int AMP    = 32767
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     smp_valid,
    input  logic signed [CTRL_W-1:0] loop_ctrl,
    output logic signed [OUT_W-1:0]  ref_cos,
    output logic signed [OUT_W-1:0]  ref_sin,
    output logic        [ACC_W-1:0]  freq_word
);
    localparam logic [ACC_W-1:0]    CENTER  = ACC_W'(1) << (ACC_W - 2);
    localparam logic [ACC_W-1:0]    SPAN    = ACC_W'(LIMIT) * ACC_W'(STEP);
    localparam logic [ACC_W-1:0]    INC_MAX = CENTER + SPAN;
    localparam logic [ACC_W-1:0]    INC_MIN = CENTER - SPAN;
    localparam logic [TABLE_AW-1:0] QTR     = TABLE_AW'(1) << (TABLE_AW - 2);

    logic [ACC_W-1:0]    next_inc;
    logic [ACC_W-1:0]    phase;
    logic [TABLE_AW-1:0] sin_addr;
    logic [TABLE_AW-1:0] cos_addr;

    nco_tune #(
        .CTRL_W (CTRL_W),
        .ACC_W  (ACC_W),
        .LIMIT  (LIMIT),
        .STEP   (STEP)
    ) u_tune (
        .ctrl_in (loop_ctrl),
        .inc_out (next_inc)
    );

    nco_phase_acc #(
        .ACC_W (ACC_W)
    ) u_acc (
        .clk     (clk),
        .rst     (rst),
        .step_en (smp_valid),
        .inc_in  (next_inc),
        .phase_o (phase),
        .inc_o   (freq_word)
    );

    assign sin_addr = phase[ACC_W-1 -: TABLE_AW];
    assign cos_addr = sin_addr + QTR;

    nco_quarter_lut #(.OUT_W(OUT_W), .AMP(AMP)) u_lut_sin (
        .addr   (sin_addr),
        .sample (ref_sin)
    );

    nco_quarter_lut #(.OUT_W(OUT_W), .AMP(AMP)) u_lut_cos (
        .addr   (cos_addr),
        .sample (ref_cos)
    );

    // R2: reported increment stays inside the tuning window
    p_window_r2: assert property (@(posedge clk) disable iff (rst)
        (freq_word >= INC_MIN && freq_word <= INC_MAX));

    // R3: sign of the control word sets the side of the centre
    p_raise_r3: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && loop_ctrl > 0) |=> (freq_word > CENTER));
    p_lower_r3: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && loop_ctrl < 0) |=> (freq_word < CENTER));

    // R7: quadrature relation of the two outputs in the upper half turn
    p_first_quad_r7: assert property (@(posedge clk) disable iff (rst)
        (phase[ACC_W-1 -: 2] == 2'b00) |-> (ref_sin > 0 && ref_cos > 0));
    p_second_quad_r7: assert property (@(posedge clk) disable iff (rst)
        (phase[ACC_W-1 -: 2] == 2'b01) |-> (ref_sin > 0 && ref_cos < 0));

endmodule

// File: tb/quad_nco_bench.sv
module quad_nco_bench;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               smp_valid = 1'b0;
    logic signed [15:0] loop_ctrl = '0;
    logic signed [15:0] ref_cos;
    logic signed [15:0] ref_sin;
    logic [31:0]        freq_word;

    always #10 clk = ~clk;

    quad_nco u_quad_nco (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .loop_ctrl (loop_ctrl),
        .ref_cos   (ref_cos),
        .ref_sin   (ref_sin),
        .freq_word (freq_word)
    );

    typedef struct {
        logic [31:0] freq;
        logic [31:0] acc;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    logic [31:0] m_acc = '0;
    logic [31:0] m_inc = 32'h4000_0000;
    bit          done  = 0;

    function automatic int ref_point(input int p);
        real a;
        real v;
        a = 2.0 * 3.141592653589793 * (real'(p) + 0.5) / 256.0;
        v = 32767.0 * $sin(a);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(-v + 0.5);
    endfunction

    function automatic logic [31:0] model_inc(input int c);
        int     cl;
        longint t;
        cl = (c > 2000) ? 2000 : ((c < -2000) ? -2000 : c);
        t  = 64'sd1073741824 + longint'(cl) * 64'sd20133;
        return t[31:0];
    endfunction

    task automatic check_now(input exp_t e);
        int p;
        int es;
        int ec;
        p  = int'(e.acc[31:24]);
        es = ref_point(p);
        ec = ref_point((p + 64) % 256);
        n_cmp++;
        if (freq_word !== e.freq) begin
            n_bad++;
            $display("FAIL %s freq_word: actual %h expected %h", e.tag, freq_word, e.freq);
        end
        n_cmp++;
        if (int'(ref_sin) > es + 2 || int'(ref_sin) < es - 2) begin
            n_bad++;
            $display("FAIL %s/R6 ref_sin: actual %0d expected %0d", e.tag, ref_sin, es);
        end
        n_cmp++;
        if (int'(ref_cos) > ec + 2 || int'(ref_cos) < ec - 2) begin
            n_bad++;
            $display("FAIL %s/R7 ref_cos: actual %0d expected %0d", e.tag, ref_cos, ec);
        end
    endtask

    // Driver: one strobe with control word c
    task automatic step(input int c, input string tag);
        exp_t e;
        @(negedge clk);
        smp_valid = 1'b1;
        loop_ctrl = 16'(c);
        @(posedge clk);
        m_inc = model_inc(c);
        m_acc = m_acc + m_inc;
        e.freq = m_inc;
        e.acc  = m_acc;
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    // Driver: idle cycle with a disturbing control word
    task automatic idle(input int c);
        exp_t e;
        @(negedge clk);
        smp_valid = 1'b0;
        loop_ctrl = 16'(c);
        @(posedge clk);
        e.freq = m_inc;
        e.acc  = m_acc;
        e.tag  = "R5";
        exp_q.push_back(e);
    endtask

    // Monitor
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) check_now(exp_q.pop_front());
        end
    end

    initial begin
        exp_t e;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        e.freq = 32'h4000_0000;
        e.acc  = '0;
        e.tag  = "R1";
        check_now(e);

        for (int i = 0; i < 60; i++) step(0, "R4");
        for (int i = 0; i < 60; i++) step(1500, "R3");
        for (int i = 0; i < 60; i++) step(-1700, "R3");
        for (int i = 0; i < 40; i++) step(30000, "R2");
        for (int i = 0; i < 40; i++) step(-32768, "R2");
        step(2000, "R2");
        step(-2000, "R2");
        step(2001, "R2");
        step(-2001, "R2");
        for (int i = 0; i < 12; i++) idle(((i % 2) == 0) ? 32767 : -32768);
        for (int i = 0; i < 300; i++) step((i * 37) % 4001 - 2000, "R8");
        for (int i = 0; i < 8; i++) idle(1234);
        for (int i = 0; i < 400; i++) step(2000, "R4");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule